// File: doc/BRIEF.md
# Prescaled 8-bit Overflow Timer

This block is an 8-bit up-counter that advances on ticks taken from a shared 10-bit free-running prescaler on the I/O clock, or from edges of an external count pin. The pin is first brought into the I/O clock domain by a two-flop synchronizer. A 3-bit clock-select field chooses the tick source: stopped, one of five divide ratios, or the falling or rising edge of the pin. Software reaches four registers over a small register bus. It can read or write the count register at any time. An interrupt handler that rewrites the count with a reload value shortens the interval between overflows.

When the count wraps from its maximum to zero, a sticky overflow flag is set. The flag raises an interrupt request only while its mask bit and a global interrupt-enable input are both high. The flag is cleared by an interrupt-acknowledge pulse, or by software writing a 1 to it.

Register map (2-bit address): 0 = clock select in bits [2:0]; 1 = count; 2 = overflow interrupt mask in bit 0; 3 = overflow flag in bit 0. Unused read bits return 0. Writes take effect at the clock edge that ends the cycle in which the write strobe is high. Reads are combinational on the address.

Top module: `tick_timer8`

## Requirements
- R1: After reset, all four registers read 0 and the interrupt request is low.
- R2: The prescaler is 10 bits wide. It is 0 after reset and advances by one every I/O clock. Clock-select 001 ticks every cycle. Codes 010, 011, 100 and 101 tick in the cycles where the prescaler's low 3, 6, 8 or 10 bits are all ones, which divides by 8, 64, 256 and 1024.
- R3: With clock-select 000 the count holds its value.
- R4: The count register (address 1) is readable and writable. It rises by one at each tick and wraps from 0xFF to 0x00.
- R5: A count write in the same cycle as a tick loads the written value. That tick is dropped and causes no overflow.
- R6: A tick taken while the count is 0xFF sets the overflow flag (address 3, bit 0).
- R7: The flag clears on an intAck pulse, or on a write to address 3 with data bit 0 high. A write with bit 0 low leaves the flag unchanged. A new overflow in the same cycle as a clear leaves the flag set.
- R8: irq is high exactly when the flag, the mask (address 2, bit 0) and globalIntEn are all high.
- R9: Clock-select 111 counts rising edges of extPin and 110 counts falling edges. Each qualifying edge gives exactly one increment. The increment lands on the third rising clock edge after the pin changes, and the pin is never prescaled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdData | output | 8 | Read data for addr |
| extPin | input | 1 | External count pin, asynchronous |
| globalIntEn | input | 1 | Global interrupt enable |
| intAck | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
Directed sequences cover three cases. The /1 ratio is run from a preloaded 0xFE, which separates a correct wrap-and-flag from an off-by-one. The stopped setting is held for many cycles, which exposes any stray tick. The two pin polarities are driven with the same pulse, so a swapped edge selection gives a different count. Random mixes of clock-select changes, count writes that collide with ticks, flag writes of 0 and 1, acknowledges, mask and enable toggles, and slow pin toggles are compared every cycle against a bench model. That comparison shows whether the prescaler phase, the write-over-tick priority and the set-over-clear order are each right.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int ADDR_W = 2;
  localparam int CSEL_W = 3;
  localparam int N_TAPS = 5;
  // low prescaler bits that must be all ones for each divide ratio
  localparam int TAP_LOG2 [N_TAPS] = '{0, 3, 6, 8, 10};

  localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] REG_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] REG_MASK = 2'd2;
  localparam logic [ADDR_W-1:0] REG_FLAG = 2'd3;

  typedef enum logic [CSEL_W-1:0] {
    CS_STOP    = 3'd0,
    CS_DIV1    = 3'd1,
    CS_DIV8    = 3'd2,
    CS_DIV64   = 3'd3,
    CS_DIV256  = 3'd4,
    CS_DIV1024 = 3'd5,
    CS_EXTFALL = 3'd6,
    CS_EXTRISE = 3'd7
  } csel_e;

  typedef struct packed {
    logic loadCnt;
    logic incCnt;
    logic loadMask;
    logic clrFlag;
  } strb_t;
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [N_TAPS-1:0] tapTick
);
  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    if (TAP_LOG2[i] == 0) begin : g_every
      assign tapTick[i] = 1'b1;
    end else begin : g_masked
      assign tapTick[i] = &preCnt[TAP_LOG2[i]-1:0];
    end
  end
endmodule

// File: rtl/tmr8_extsync.sv
module tmr8_extsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic extPin,
  output logic riseHit,
  output logic fallHit
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], extPin};
      prevQ <= syncQ[STAGES-1];
    end
  end

  assign riseHit = syncQ[STAGES-1] & ~prevQ;
  assign fallHit = ~syncQ[STAGES-1] & prevQ;
endmodule

// File: rtl/tmr8_ctrl.sv
module tmr8_ctrl
  import tmr8_pkg::*;
#(
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CSEL_W-1:0] wrLow,
  input  logic              wrEn,
  input  logic              intAck,
  input  logic              extPin,
  output logic [CSEL_W-1:0] cselVal,
  output strb_t             strb
);
  csel_e             cselQ;
  logic [N_TAPS-1:0] tapTick;
  logic              riseHit;
  logic              fallHit;
  logic              tick;

  tmr8_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rstN   (rstN),
    .tapTick(tapTick)
  );

  tmr8_extsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .extPin (extPin),
    .riseHit(riseHit),
    .fallHit(fallHit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cselQ <= CS_STOP;
    else if (wrEn && addr == REG_CTRL)  cselQ <= csel_e'(wrLow);
  end

  always_comb begin
    unique case (cselQ)
      CS_STOP:    tick = 1'b0;
      CS_DIV1:    tick = tapTick[0];
      CS_DIV8:    tick = tapTick[1];
      CS_DIV64:   tick = tapTick[2];
      CS_DIV256:  tick = tapTick[3];
      CS_DIV1024: tick = tapTick[4];
      CS_EXTFALL: tick = fallHit;
      CS_EXTRISE: tick = riseHit;
      default:    tick = 1'b0;
    endcase
  end

  always_comb begin
    strb.loadCnt  = wrEn && addr == REG_CNT;
    strb.incCnt   = tick && !strb.loadCnt;
    strb.loadMask = wrEn && addr == REG_MASK;
    strb.clrFlag  = intAck || (wrEn && addr == REG_FLAG && wrLow[0]);
  end

  assign cselVal = cselQ;
endmodule

// File: rtl/tmr8_datapath.sv
module tmr8_datapath
  import tmr8_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CSEL_W-1:0] cselVal,
  input  logic              globalIntEn,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  cntVal,
  output logic              ovfFlag,
  output logic              irq
);
  logic cntMax;
  logic ovfHit;
  logic ovfMask;

  assign cntMax = &cntVal;
  assign ovfHit = strb.incCnt && cntMax;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntVal <= '0;
    else if (strb.loadCnt) cntVal <= wrData[CNT_W-1:0];
    else if (strb.incCnt)  cntVal <= cntVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ovfFlag <= 1'b0;
    else if (ovfHit)       ovfFlag <= 1'b1;
    else if (strb.clrFlag) ovfFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ovfMask <= 1'b0;
    else if (strb.loadMask) ovfMask <= wrData[0];
  end

  assign irq = ovfFlag & ovfMask & globalIntEn;

  always_comb begin
    rdData = '0;
    unique case (addr)
      REG_CTRL: rdData[CSEL_W-1:0] = cselVal;
      REG_CNT:  rdData[CNT_W-1:0]  = cntVal;
      REG_MASK: rdData[0]          = ovfMask;
      REG_FLAG: rdData[0]          = ovfFlag;
      default:  rdData             = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import tmr8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DATA_W      = 8,
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              extPin,
  input  logic              globalIntEn,
  input  logic              intAck,
  output logic              irq
);
  strb_t             strb;
  logic [CSEL_W-1:0] cselVal;
  logic [CNT_W-1:0]  cntVal;
  logic              ovfFlag;

  tmr8_ctrl #(.PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wrLow  (wrData[CSEL_W-1:0]),
    .wrEn   (wrEn),
    .intAck (intAck),
    .extPin (extPin),
    .cselVal(cselVal),
    .strb   (strb)
  );

  tmr8_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addr       (addr),
    .wrData     (wrData),
    .cselVal    (cselVal),
    .globalIntEn(globalIntEn),
    .rdData     (rdData),
    .cntVal     (cntVal),
    .ovfFlag    (ovfFlag),
    .irq        (irq)
  );
endmodule

// File: rtl/tick_timer8_chk.sv
module tick_timer8_chk
  import tmr8_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrEn,
  input logic              globalIntEn,
  input logic              intAck,
  input logic              irq,
  input logic [CNT_W-1:0]  cntVal,
  input logic              ovfFlag,
  input logic              incCnt,
  input logic              loadCnt,
  input logic [CSEL_W-1:0] cselVal
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ovfFlag && globalIntEn)); // R8

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (cselVal == 3'd0 && !(wrEn && addr == REG_CNT)) |=> $stable(cntVal)); // R3

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_CNT) |=> (cntVal == $past(wrData[CNT_W-1:0]))); // R5

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (incCnt && !loadCnt && cntVal != '1) |=> (cntVal == $past(cntVal) + 1'b1)); // R4

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (incCnt && cntVal == '1) |=> (ovfFlag && cntVal == '0)); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !(incCnt && cntVal == '1)) |=> !ovfFlag); // R7
endmodule

bind tick_timer8 tick_timer8_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addr       (addr),
  .wrData     (wrData),
  .wrEn       (wrEn),
  .globalIntEn(globalIntEn),
  .intAck     (intAck),
  .irq        (irq),
  .cntVal     (cntVal),
  .ovfFlag    (ovfFlag),
  .incCnt     (strb.incCnt),
  .loadCnt    (strb.loadCnt),
  .cselVal    (cselVal)
);

// File: tb/tick_timer8_tb.sv
`timescale 1ns/1ps
module tick_timer8_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       wrEn = 1'b0;
  logic [7:0] rdData;
  logic       extPin = 1'b0;
  logic       globalIntEn = 1'b0;
  logic       intAck = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_timer8 u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdData(rdData), .extPin(extPin), .globalIntEn(globalIntEn),
    .intAck(intAck), .irq(irq)
  );

  // reference model built from the requirements
  logic [9:0] mPre;
  logic [2:0] mCsel;
  logic [7:0] mCnt;
  logic       mFlag, mMask, mPrev;
  logic [1:0] mSync;

  function automatic logic expTick(input logic [2:0] cs, input logic [9:0] pre,
                                   input logic s, input logic p);
    case (cs)
      3'd1: return 1'b1;
      3'd2: return &pre[2:0];
      3'd3: return &pre[5:0];
      3'd4: return &pre[7:0];
      3'd5: return &pre;
      3'd6: return !s && p;
      3'd7: return s && !p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {5'd0, mCsel};
      2'd1: return mCnt;
      2'd2: return {7'd0, mMask};
      default: return {7'd0, mFlag};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPre <= '0; mCsel <= '0; mCnt <= '0; mFlag <= 1'b0;
      mMask <= 1'b0; mSync <= '0; mPrev <= 1'b0;
    end else begin
      logic tk, ld;
      tk = expTick(mCsel, mPre, mSync[1], mPrev);
      ld = wrEn && addr == 2'd1;
      if (ld) mCnt <= wrData;
      else if (tk) mCnt <= mCnt + 8'd1;
      if (tk && !ld && mCnt == 8'hFF) mFlag <= 1'b1;
      else if (intAck || (wrEn && addr == 2'd3 && wrData[0])) mFlag <= 1'b0;
      if (wrEn && addr == 2'd2) mMask <= wrData[0];
      if (wrEn && addr == 2'd0) mCsel <= wrData[2:0];
      mPre <= mPre + 10'd1;
      mSync <= {mSync[0], extPin};
      mPrev <= mSync[1];
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      string tg;
      case (addr)
        2'd0: tg = "R2 ctrl";
        2'd1: tg = "R4 count";
        2'd2: tg = "R8 mask";
        default: tg = "R6 flag";
      endcase
      chk(tg, rdData, expRead(addr));
      chk("R8 irq", {7'd0, irq}, {7'd0, mFlag & mMask & globalIntEn});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic finishUp;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishUp();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #2 rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      peek(a[1:0], v); chk("R1 reset reg", v, 8'h00);
    end
    chk("R1 reset irq", {7'd0, irq}, 8'h00);

    // R3 stopped counter holds
    wr(2'd1, 8'h05);
    idle(60);
    peek(2'd1, v); chk("R3 stopped", v, 8'h05);

    // R4/R5/R6 wrap at /1 from preload
    wr(2'd0, 8'h01);
    wr(2'd1, 8'hFE);
    peek(2'd1, v); chk("R5 write over tick", v, 8'hFE);
    idle(1); peek(2'd1, v); chk("R4 step", v, 8'hFF);
    idle(1); peek(2'd1, v); chk("R4 wrap", v, 8'h00);
    peek(2'd3, v); chk("R6 flag set", v, 8'h01);
    wr(2'd0, 8'h00);

    // R7 write 0 ignored, write 1 clears
    wr(2'd3, 8'hFE);
    peek(2'd3, v); chk("R7 write0 ignored", v, 8'h01);
    // R8 gating
    wr(2'd2, 8'h01);
    globalIntEn = 1'b1; #1;
    chk("R8 irq on", {7'd0, irq}, 8'h01);
    globalIntEn = 1'b0; #1;
    chk("R8 irq gated", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'h01);
    peek(2'd3, v); chk("R7 write1 clears", v, 8'h00);

    // R7 ack clears a new overflow
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h00);
    peek(2'd3, v); chk("R6 flag again", v, 8'h01);
    intAck = 1'b1; idle(1); intAck = 1'b0;
    peek(2'd3, v); chk("R7 ack clears", v, 8'h00);

    // R9 external edges
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h07);
    extPin = 1'b1; idle(2);
    peek(2'd1, v); chk("R9 not yet", v, 8'h10);
    idle(1); peek(2'd1, v); chk("R9 rise counted", v, 8'h11);
    extPin = 1'b0; idle(6);
    peek(2'd1, v); chk("R9 fall ignored", v, 8'h11);
    wr(2'd0, 8'h06);
    extPin = 1'b1; idle(6);
    peek(2'd1, v); chk("R9 rise ignored", v, 8'h11);
    extPin = 1'b0; idle(6);
    peek(2'd1, v); chk("R9 fall counted", v, 8'h12);

    // R2 /8 directed then random mix, checked every cycle by the model
    wr(2'd0, 8'h02);
    idle(40);
    for (int it = 0; it < 4000; it++) begin
      int op;
      op = $urandom % 10;
      case (op)
        0: wr(2'd0, 8'($urandom % 8));
        1: wr(2'd1, ($urandom % 3 == 0) ? 8'hFF : 8'($urandom));
        2: wr(2'd3, 8'($urandom % 2));
        3: wr(2'd2, 8'($urandom % 2));
        4: begin intAck = 1'b1; idle(1); intAck = 1'b0; end
        5: begin globalIntEn = $urandom % 2; idle(1); end
        6: begin extPin = ~extPin; idle(3); end
        default: begin addr = 2'($urandom % 4); idle(1 + $urandom % 20); end
      endcase
    end
    idle(2);
    finishUp();
  end
endmodule